// File: doc/BRIEF.md
# PCI Target Configuration Space and Address Decode

This block is the register and decode core of a 32-bit PCI target. It captures the multiplexed address/data lines and the command/byte-enable lines in input flops before any logic acts on them. It holds a small configuration space of identification values, a command register, a memory base register, an I/O base register and an interrupt routing byte. Configuration writes update the writable fields, with each byte gated by its byte enable. Configuration reads return any of these fields through a read-back multiplexer, which also carries local-memory data during ordinary read cycles.

The bus controller marks the address phase and each data phase with one-cycle strobes. Two clocks after an address strobe, the block reports one of three results: a configuration cycle, a memory-space hit, or an I/O-space hit. Each hit is qualified by the matching enable bit in the command register. For read data phases, the block registers the outgoing word. One clock later it drives the even parity bit, which covers that word and the byte enables of the phase. No clock is gated anywhere: every load is a flop with a clock enable.

Top module: `tgt_cfg_decode`

## Requirements
- R1: After reset, `mem_hit`, `io_hit`, `cfg_hit`, `ad_out` and `par_out` are 0. The command enables and both base registers are 0, so the I/O base register reads 0x00000001.
- R2: An address phase is a configuration cycle when `idsel_in` is 1 and the command is 4'b1010 (read) or 4'b1011 (write). The dword index is address bits [7:2]. Index 0 reads {device ID, vendor ID}, index 1 reads {status, command}, index 2 reads {class code, revision}, index 4 reads the memory base, index 5 reads the I/O base, and index 15 reads {16'h0, interrupt pin, interrupt line}. All other indices read 0.
- R3: The vendor ID, device ID, status, class code, revision and interrupt pin are fixed by parameters. Configuration writes to them leave them unchanged.
- R4: In a configuration write, byte k of the addressed register is updated only when `cbe_n_in[k]` is 0 in the data phase.
- R5: In the memory base register, bits [31:12] are writable and bits [11:0] always read 0, so bit 0 reads 0 (memory space). This gives a 4 KB window.
- R6: In the I/O base register, bits [31:8] are writable, bits [7:1] read 0 and bit 0 reads 1. This gives a 256-byte window.
- R7: `mem_hit` is 1 when four conditions hold: the command has bits [3:1] = 3'b011, `idsel_in` plays no part, address bits [31:12] equal the memory base, and command-register bit 1 is set.
- R8: `io_hit` is 1 when three conditions hold: the command has bits [3:1] = 3'b001, address bits [31:8] equal the I/O base, and command-register bit 0 is set.
- R9: Only bits [1:0] of the command register are writable, and the other bits read 0. Clearing bit 1 suppresses memory hits. Clearing bit 0 suppresses I/O hits.
- R10: In a data phase whose command has bit 0 = 0, `ad_out` takes the configuration read data in a configuration cycle and `mem_rdata` otherwise. The new value is visible after the second rising edge following the data strobe.
- R11: `par_out` is updated one clock after `ad_out`. It equals the XOR of all 32 bits of `ad_out` and the 4 byte enables of that phase, so the 37 bits together have even parity.
- R12: The three cycle results are registered on the second rising edge after the address strobe and are held until the next address phase.
- R13: Data phases of non-configuration cycles do not change any register, and neither do configuration-write commands without `idsel_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_in | input | 32 | Address/data lines from the bus |
| cbe_n_in | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| idsel_in | input | 1 | Configuration select for this device |
| addr_phase | input | 1 | Strobe: address phase on the inputs this cycle |
| data_phase | input | 1 | Strobe: data phase on the inputs this cycle |
| mem_rdata | input | 32 | Read data from the local memory |
| ad_out | output | 32 | Registered read-back data |
| par_out | output | 1 | Even parity over the previous `ad_out` and its byte enables |
| mem_hit | output | 1 | Latched cycle claimed in memory space |
| io_hit | output | 1 | Latched cycle claimed in I/O space |
| cfg_hit | output | 1 | Latched cycle is a configuration cycle to this device |

## Verification
Each result is due at a fixed distance from its strobe. Hit and configuration flags are due two edges after the address strobe. A register write takes effect two edges after its data strobe. Read data is due two edges after its data strobe, and parity is due on the edge after that. Every bench task drives its inputs on a falling edge and waits exactly those edges. It then samples on the following falling edge, so each check looks at the first cycle in which the value is due. The checker verifies the same distances with `|=>` properties, and also checks that the flags do not move between address strobes.

// File: rtl/tgt_cfg_pkg.sv
package tgt_cfg_pkg;

  localparam logic [2:0] CLS_IO  = 3'b001;
  localparam logic [2:0] CLS_MEM = 3'b011;
  localparam logic [2:0] CLS_CFG = 3'b101;

  localparam logic [5:0] IDX_IDENT   = 6'd0;
  localparam logic [5:0] IDX_CMDSTAT = 6'd1;
  localparam logic [5:0] IDX_CLASS   = 6'd2;
  localparam logic [5:0] IDX_MBASE   = 6'd4;
  localparam logic [5:0] IDX_IOBASE  = 6'd5;
  localparam logic [5:0] IDX_IRQ     = 6'd15;

  // Even parity bit over a data word and its byte enables.
  function automatic logic even_par(input logic [31:0] d, input logic [3:0] be_n);
    return (^d) ^ (^be_n);
  endfunction

  // Replace the bytes whose active-low enable is 0.
  function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be_n);
    logic [31:0] r;
    r = old_w;
    for (int k = 0; k < 4; k++)
      if (!be_n[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction

  // Address lies in the naturally aligned window of 2**lg2 bytes at base.
  function automatic logic win_match(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned lg2);
    return ((addr ^ base) >> lg2) == 32'd0;
  endfunction

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import tgt_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [15:0] STATUS_VAL = 16'h0200,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [7:0]  IRQ_PIN    = 8'h01,
  parameter int unsigned MEM_LG2    = 12,
  parameter int unsigned IO_LG2     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  idx,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_be_n,
  output logic [31:0] rd_data,
  output logic        mem_en,
  output logic        io_en,
  output logic [31:0] mem_bar,
  output logic [31:0] io_bar
);

  localparam int unsigned MBW = 32 - MEM_LG2;
  localparam int unsigned IBW = 32 - IO_LG2;

  logic [1:0]     cmd_q;
  logic [MBW-1:0] mbase_q;
  logic [IBW-1:0] iobase_q;
  logic [7:0]     irq_line_q;
  logic [31:0]    merged;

  assign mem_en  = cmd_q[1];
  assign io_en   = cmd_q[0];
  assign mem_bar = {mbase_q, {MEM_LG2{1'b0}}};
  assign io_bar  = {iobase_q, {(IO_LG2-1){1'b0}}, 1'b1};

  always_comb begin
    case (idx)
      IDX_IDENT:   rd_data = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTAT: rd_data = {STATUS_VAL, 14'd0, cmd_q};
      IDX_CLASS:   rd_data = {CLASS_CODE, REV_ID};
      IDX_MBASE:   rd_data = mem_bar;
      IDX_IOBASE:  rd_data = io_bar;
      IDX_IRQ:     rd_data = {16'd0, IRQ_PIN, irq_line_q};
      default:     rd_data = 32'd0;
    endcase
  end

  assign merged = byte_merge(rd_data, wr_data, wr_be_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      mbase_q    <= '0;
      iobase_q   <= '0;
      irq_line_q <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_CMDSTAT: cmd_q      <= merged[1:0];
        IDX_MBASE:   mbase_q    <= merged[31:MEM_LG2];
        IDX_IOBASE:  iobase_q   <= merged[31:IO_LG2];
        IDX_IRQ:     irq_line_q <= merged[7:0];
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/bar_decode.sv
module bar_decode
  import tgt_cfg_pkg::*;
#(
  parameter int unsigned MEM_LG2 = 12,
  parameter int unsigned IO_LG2  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lat_en,
  input  logic [31:0] addr,
  input  logic [3:0]  cmd,
  input  logic        idsel,
  input  logic [31:0] mem_bar,
  input  logic [31:0] io_bar,
  input  logic        mem_en,
  input  logic        io_en,
  output logic        mem_hit,
  output logic        io_hit,
  output logic        cfg_hit,
  output logic [5:0]  cfg_idx,
  output logic        cyc_write
);

  logic mem_match, io_match, mem_d, io_d, cfg_d;

  assign mem_match = win_match(addr, mem_bar, MEM_LG2);
  assign io_match  = win_match(addr, io_bar, IO_LG2);
  assign mem_d = (cmd[3:1] == CLS_MEM) && mem_en && mem_match;
  assign io_d  = (cmd[3:1] == CLS_IO) && io_en && io_match;
  assign cfg_d = (cmd[3:1] == CLS_CFG) && idsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_hit   <= 1'b0;
      io_hit    <= 1'b0;
      cfg_hit   <= 1'b0;
      cfg_idx   <= '0;
      cyc_write <= 1'b0;
    end else if (lat_en) begin
      mem_hit   <= mem_d;
      io_hit    <= io_d;
      cfg_hit   <= cfg_d;
      cfg_idx   <= addr[7:2];
      cyc_write <= cmd[0];
    end
  end

endmodule

// File: rtl/rdback_parity.sv
module rdback_parity
  import tgt_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        sel_cfg,
  input  logic [31:0] cfg_data,
  input  logic [31:0] mem_data,
  input  logic [3:0]  be_n,
  output logic [31:0] ad_out,
  output logic [3:0]  be_hold,
  output logic        par_out
);

  logic par_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_out   <= '0;
      be_hold  <= '0;
      par_pend <= 1'b0;
      par_out  <= 1'b0;
    end else begin
      par_pend <= load;
      if (load) begin
        ad_out  <= sel_cfg ? cfg_data : mem_data;
        be_hold <= be_n;
      end
      if (par_pend) par_out <= even_par(ad_out, be_hold);
    end
  end

endmodule

// File: rtl/tgt_cfg_decode.sv
module tgt_cfg_decode
  import tgt_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [15:0] STATUS_VAL = 16'h0200,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [7:0]  IRQ_PIN    = 8'h01,
  parameter int unsigned MEM_LG2    = 12,
  parameter int unsigned IO_LG2     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n_in,
  input  logic        idsel_in,
  input  logic        addr_phase,
  input  logic        data_phase,
  input  logic [31:0] mem_rdata,
  output logic [31:0] ad_out,
  output logic        par_out,
  output logic        mem_hit,
  output logic        io_hit,
  output logic        cfg_hit
);

  // Input capture: nothing decodes the raw bus lines.
  logic [31:0] ad_q;
  logic [3:0]  cbe_q;
  logic        idsel_q, aph_q, dph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q    <= '0;
      cbe_q   <= '1;
      idsel_q <= 1'b0;
      aph_q   <= 1'b0;
      dph_q   <= 1'b0;
    end else begin
      ad_q    <= ad_in;
      cbe_q   <= cbe_n_in;
      idsel_q <= idsel_in;
      aph_q   <= addr_phase;
      dph_q   <= data_phase;
    end
  end

  // Named internal events for the checker.
  logic [5:0]  cfg_idx;
  logic        cyc_write, cfg_wr, rd_load;
  logic [31:0] cfg_rdata, mem_bar, io_bar;
  logic        mem_en, io_en;
  logic [3:0]  be_hold;

  assign cfg_wr  = dph_q && cfg_hit && cyc_write;
  assign rd_load = dph_q && !cyc_write;

  cfg_regfile #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .STATUS_VAL(STATUS_VAL),
    .CLASS_CODE(CLASS_CODE), .REV_ID(REV_ID), .IRQ_PIN(IRQ_PIN),
    .MEM_LG2(MEM_LG2), .IO_LG2(IO_LG2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .idx(cfg_idx), .wr_en(cfg_wr),
    .wr_data(ad_q), .wr_be_n(cbe_q), .rd_data(cfg_rdata),
    .mem_en(mem_en), .io_en(io_en), .mem_bar(mem_bar), .io_bar(io_bar)
  );

  bar_decode #(.MEM_LG2(MEM_LG2), .IO_LG2(IO_LG2)) u_dec (
    .clk(clk), .rst_n(rst_n), .lat_en(aph_q), .addr(ad_q), .cmd(cbe_q),
    .idsel(idsel_q), .mem_bar(mem_bar), .io_bar(io_bar),
    .mem_en(mem_en), .io_en(io_en), .mem_hit(mem_hit), .io_hit(io_hit),
    .cfg_hit(cfg_hit), .cfg_idx(cfg_idx), .cyc_write(cyc_write)
  );

  rdback_parity u_rbk (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .sel_cfg(cfg_hit),
    .cfg_data(cfg_rdata), .mem_data(mem_rdata), .be_n(cbe_q),
    .ad_out(ad_out), .be_hold(be_hold), .par_out(par_out)
  );

endmodule

// File: rtl/tgt_cfg_decode_chk.sv
module tgt_cfg_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        aph_q,
  input logic        rd_load,
  input logic        mem_hit,
  input logic        io_hit,
  input logic        cfg_hit,
  input logic        mem_en,
  input logic        io_en,
  input logic [31:0] ad_out,
  input logic [3:0]  be_hold,
  input logic        par_out,
  input logic [31:0] mem_bar,
  input logic [31:0] io_bar
);

  // R7 / R8: the command classes are disjoint, so one space at most
  p_one_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_hit && io_hit));

  // R2: a configuration cycle never claims memory or I/O space
  p_cfg_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |-> !(mem_hit || io_hit));

  // R9: hits require their enable bit
  p_mem_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> mem_en);
  p_io_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> io_en);

  // R11: parity one clock after the loaded word
  p_par_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> ##1 (par_out == ^{$past(ad_out), $past(be_hold)}));

  // R12: results move only after an address strobe
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !aph_q |=> ($stable(mem_hit) && $stable(io_hit) && $stable(cfg_hit)));

  // R13: base registers change only inside configuration cycles
  p_bar_guard_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> ($stable(mem_bar) && $stable(io_bar)));

endmodule

bind tgt_cfg_decode tgt_cfg_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aph_q(aph_q), .rd_load(rd_load),
  .mem_hit(mem_hit), .io_hit(io_hit), .cfg_hit(cfg_hit),
  .mem_en(mem_en), .io_en(io_en), .ad_out(ad_out), .be_hold(be_hold),
  .par_out(par_out), .mem_bar(mem_bar), .io_bar(io_bar)
);

// File: tb/tgt_cfg_decode_tb.sv
`timescale 1ns/1ps
module tgt_cfg_decode_tb;

  localparam logic [15:0] VEN  = 16'hC0DE;
  localparam logic [15:0] DEV  = 16'h5A17;
  localparam logic [15:0] STAT = 16'h0200;
  localparam logic [23:0] CLS  = 24'h118000;
  localparam logic [7:0]  REV  = 8'h03;
  localparam logic [7:0]  PIN  = 8'h01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n_in = '1;
  logic        idsel_in = 1'b0, addr_phase = 1'b0, data_phase = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] ad_out;
  logic        par_out, mem_hit, io_hit, cfg_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench shadow of the writable state
  logic [1:0]  sh_cmd = '0;
  logic [31:0] sh_mbar = 32'h0;
  logic [31:0] sh_iobar = 32'h1;
  logic [7:0]  sh_irq = '0;

  always #10 clk = ~clk;

  tgt_cfg_decode u_dut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n_in(cbe_n_in),
    .idsel_in(idsel_in), .addr_phase(addr_phase), .data_phase(data_phase),
    .mem_rdata(mem_rdata), .ad_out(ad_out), .par_out(par_out),
    .mem_hit(mem_hit), .io_hit(io_hit), .cfg_hit(cfg_hit)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] idx);
    case (idx)
      6'd0:    return {DEV, VEN};
      6'd1:    return {STAT, 14'd0, sh_cmd};
      6'd2:    return {CLS, REV};
      6'd4:    return sh_mbar;
      6'd5:    return sh_iobar;
      6'd15:   return {16'd0, PIN, sh_irq};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] merge_be(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] m;
    m = {be[3] ? o[31:24] : n[31:24], be[2] ? o[23:16] : n[23:16],
         be[1] ? o[15:8] : n[15:8], be[0] ? o[7:0] : n[7:0]};
    return m;
  endfunction

  function automatic logic par_of(input logic [31:0] d, input logic [3:0] be);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 32; i++) p = p ^ d[i];
    for (int i = 0; i < 4; i++) p = p ^ be[i];
    return p;
  endfunction

  // All tasks start and end at a falling edge.
  task automatic bus_addr(input logic [31:0] a, input logic [3:0] c, input logic ids);
    ad_in = a; cbe_n_in = c; idsel_in = ids; addr_phase = 1'b1;
    @(negedge clk);
    addr_phase = 1'b0; idsel_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [31:0] d, input logic [3:0] be);
    ad_in = d; cbe_n_in = be; data_phase = 1'b1;
    @(negedge clk);
    data_phase = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [3:0] be, input logic [31:0] md,
                        output logic [31:0] d, output logic p);
    cbe_n_in = be; mem_rdata = md; data_phase = 1'b1;
    @(negedge clk);
    data_phase = 1'b0;
    @(negedge clk);
    d = ad_out;
    @(negedge clk);
    p = par_out;
  endtask

  task automatic cfg_write(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m;
    bus_addr({24'd0, idx, 2'b00}, 4'b1011, 1'b1);
    bus_wr(d, be);
    m = merge_be(exp_rd(idx), d, be);
    case (idx)
      6'd1:  sh_cmd = m[1:0];
      6'd4:  sh_mbar = m & 32'hFFFF_F000;
      6'd5:  sh_iobar = (m & 32'hFFFF_FF00) | 32'h1;
      6'd15: sh_irq = m[7:0];
      default: ;
    endcase
  endtask

  task automatic cfg_read_chk(input string rq, input logic [5:0] idx, input logic [3:0] be);
    logic [31:0] d;
    logic p;
    bus_addr({24'd0, idx, 2'b00}, 4'b1010, 1'b1);
    chk({rq, " cfg_hit"}, {31'd0, cfg_hit}, 32'd1);
    bus_rd(be, 32'hDEAD_BEEF, d, p);
    chk(rq, d, exp_rd(idx));
    chk("R11 parity", {31'd0, p}, {31'd0, par_of(exp_rd(idx), be)});
  endtask

  task automatic hit_chk(input string rq, input logic [31:0] a, input logic [3:0] c);
    logic em, ei;
    bus_addr(a, c, 1'b0);
    em = (c[3:1] == 3'b011) && sh_cmd[1] && (a[31:12] == sh_mbar[31:12]);
    ei = (c[3:1] == 3'b001) && sh_cmd[0] && (a[31:8] == sh_iobar[31:8]);
    chk({rq, " mem_hit"}, {31'd0, mem_hit}, {31'd0, em});
    chk({rq, " io_hit"}, {31'd0, io_hit}, {31'd0, ei});
    chk({rq, " cfg_hit"}, {31'd0, cfg_hit}, 32'd0);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic p;
    logic [31:0] addrs [8];
    logic [3:0]  cmds [5];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mem_hit", {31'd0, mem_hit}, 32'd0);
    chk("R1 io_hit", {31'd0, io_hit}, 32'd0);
    chk("R1 cfg_hit", {31'd0, cfg_hit}, 32'd0);
    chk("R1 ad_out", ad_out, 32'd0);
    chk("R1 par_out", {31'd0, par_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R1 / R3: sweep every dword index after reset
    for (int i = 0; i < 64; i++) cfg_read_chk("R2 sweep", 6'(i), 4'(i));

    // R3: writes to fixed fields leave them unchanged
    cfg_write(6'd0, 32'h0000_0000, 4'h0);
    cfg_write(6'd2, 32'hFFFF_FFFF, 4'h0);
    cfg_write(6'd1, 32'h0000_0000, 4'h0);
    cfg_read_chk("R3 ident", 6'd0, 4'h0);
    cfg_read_chk("R3 class", 6'd2, 4'h0);
    cfg_read_chk("R3 status", 6'd1, 4'h0);

    // R4 / R5 / R6 / R9: every byte-enable pattern on each writable register
    for (int b = 0; b < 16; b++) begin
      cfg_write(6'd4, 32'h1357_9BDF ^ {8{4'(b)}}, 4'(b));
      cfg_read_chk("R4 R5 mem base", 6'd4, 4'h0);
      cfg_write(6'd5, 32'hFEDC_BA98 ^ {8{4'(b)}}, 4'(b));
      cfg_read_chk("R4 R6 io base", 6'd5, 4'h0);
      cfg_write(6'd15, 32'hA5C3_3C00 | 32'(b * 17), 4'(b));
      cfg_read_chk("R4 irq line", 6'd15, 4'hF);
      cfg_write(6'd1, 32'hFFFF_FFFC | 32'(b), 4'(b));
      cfg_read_chk("R4 R9 command", 6'd1, 4'h0);
    end

    // Set windows for decode
    cfg_write(6'd4, 32'hABCD_E123, 4'h0);
    cfg_write(6'd5, 32'h0000_12FF, 4'h0);
    cfg_read_chk("R5 low bits", 6'd4, 4'h0);
    cfg_read_chk("R6 low bits", 6'd5, 4'h0);

    addrs[0] = 32'hABCD_E000; addrs[1] = 32'hABCD_EFFF;
    addrs[2] = 32'hABCD_F000; addrs[3] = 32'hABCD_DFFC;
    addrs[4] = 32'h0000_1200; addrs[5] = 32'h0000_12FF;
    addrs[6] = 32'h0000_1300; addrs[7] = 32'h0000_11FF;
    cmds[0] = 4'b0110; cmds[1] = 4'b0111; cmds[2] = 4'b0010;
    cmds[3] = 4'b0011; cmds[4] = 4'b1010;

    // R7 / R8 / R9: all enable combinations, window edges, command classes
    for (int e = 0; e < 4; e++) begin
      cfg_write(6'd1, 32'(e), 4'h0);
      for (int a = 0; a < 8; a++)
        for (int c = 0; c < 5; c++)
          hit_chk("R7 R8 R9 decode", addrs[a], cmds[c]);
    end

    // R12: results held while data phases run
    cfg_write(6'd1, 32'h3, 4'h0);
    bus_addr(32'hABCD_E040, 4'b0110, 1'b0);
    bus_rd(4'h0, 32'h0F0F_1234, d, p);
    chk("R12 mem_hit held", {31'd0, mem_hit}, 32'd1);
    chk("R10 mem data", d, 32'h0F0F_1234);
    chk("R11 parity mem", {31'd0, p}, {31'd0, par_of(32'h0F0F_1234, 4'h0)});

    // R10 / R11: memory read data under several byte-enable patterns
    for (int k = 0; k < 16; k++) begin
      logic [31:0] md;
      md = 32'h8000_0001 ^ (32'h0101_0101 * 32'(k)) ^ (32'd1 << k);
      bus_addr(32'hABCD_E000 | 32'(k * 4), 4'b0110, 1'b0);
      bus_rd(4'(k), md, d, p);
      chk("R10 mem data", d, md);
      chk("R11 parity", {31'd0, p}, {31'd0, par_of(md, 4'(k))});
    end

    // R10: I/O read also passes local data
    bus_addr(32'h0000_1210, 4'b0010, 1'b0);
    chk("R8 io_hit", {31'd0, io_hit}, 32'd1);
    bus_rd(4'h3, 32'h7777_0000, d, p);
    chk("R10 io data", d, 32'h7777_0000);
    chk("R11 parity io", {31'd0, p}, {31'd0, par_of(32'h7777_0000, 4'h3)});

    // R13: memory write, I/O write and config write without select
    bus_addr(32'hABCD_E010, 4'b0111, 1'b0);
    bus_wr(32'h0000_0000, 4'h0);
    bus_addr(32'h0000_1214, 4'b0011, 1'b0);
    bus_wr(32'h0000_0000, 4'h0);
    bus_addr({24'd0, 6'd4, 2'b00}, 4'b1011, 1'b0);
    chk("R13 cfg_hit no idsel", {31'd0, cfg_hit}, 32'd0);
    bus_wr(32'h0000_0000, 4'h0);
    bus_addr({24'd0, 6'd1, 2'b00}, 4'b1011, 1'b0);
    bus_wr(32'h0000_0000, 4'h0);
    cfg_read_chk("R13 mem base kept", 6'd4, 4'h0);
    cfg_read_chk("R13 io base kept", 6'd5, 4'h0);
    cfg_read_chk("R13 command kept", 6'd1, 4'h0);
    chk("R13 mem base value", sh_mbar, 32'hABCD_E000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule